// File: doc/BRIEF.md
# Debug-Port Memory Read Master

This block performs a single memory read across a narrow debug port made of a port clock, an active-low sync strobe and a 4-bit data bus. The bus changes direction during each transaction. A requester places a 32-bit address on `addr_i` and pulses `start_i`. The master then generates the port clock from the system clock. With sync held low, it sends a start nibble, then the read command, then the eight address nibbles. After that it releases the bus.

Once the bus is released, the master samples the bus on every port clock until the target returns the ready code. It then raises sync and collects eight data nibbles. When the read completes, it pulses `done_o` and presents the word on `data_o`. If the target never answers, a poll limit ends the transaction with `error_o` set and no data.

At the pads the data bus is split into three signals: a drive enable, an output nibble and an input nibble. The pad tristate is assembled outside this block.

Top module: `dbgrd_master`

## Requirements
- R1: While reset is asserted, and whenever no transaction is running, `sync_n_o`=1, `bus_oe_o`=0, `pclk_o`=0 and `busy_o`=0. Reset also clears `done_o`, `error_o` and `data_o`.
- R2: While busy, `pclk_o` is a square wave with a period of 2*HALF_DIV system clocks, where HALF_DIV is at least 2. Smaller values are raised to 2, so the port clock never runs faster than a quarter of the system clock. The port clock starts low.
- R3: An accepted start immediately drives `bus_oe_o`=1, `sync_n_o`=0 and `bus_out_o`=4'b0000 (the start nibble). On the next port clock cycle the master drives `bus_out_o`=4'b1010 (the read command, bit 3 first in the literal).
- R4: After the command, the address goes out as 8 nibbles on 8 consecutive port clock cycles, least significant nibble first (`addr_i[3:0]` first).
- R5: The port clock cycle after the last address nibble is an idle turnaround cycle. In that cycle `bus_oe_o`=0, `sync_n_o` stays 0, and the master does not sample the bus.
- R6: From the next cycle on, the master samples `bus_in_i` on each rising edge of `pclk_o`. It keeps polling until it reads the ready code 4'b0001.
- R7: At the falling edge after the ready code, `sync_n_o` goes to 1. The next 8 rising edges each capture one nibble, least significant first, to form `data_o`. `bus_oe_o` is 0 whenever `sync_n_o` is 1.
- R8: `done_o` is high for exactly one system clock, at the falling edge after the final captured nibble. `data_o` and `error_o` then hold until the next accepted start, and no further port clock edges occur.
- R9: Each non-ready sample is counted against `poll_limit_i`, which is captured at start. A limit of 0 acts as 1. When the count reaches the limit, the master stops polling. At the next falling edge it pulses `done_o` with `error_o`=1, `data_o`=0 and `sync_n_o`=1, with the bus released.
- R10: `start_i` is ignored while busy. A new address presented during a transaction has no effect on the nibbles sent.
- R11: `bus_out_o`, `bus_oe_o` and `sync_n_o` change only while `pclk_o` is low, or together with its falling edge. They never change while `pclk_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse for one read |
| addr_i | input | 32 | Address to read, sampled at start |
| poll_limit_i | input | 16 | Maximum non-ready poll samples, sampled at start |
| pclk_o | output | 1 | Port clock |
| sync_n_o | output | 1 | Active-low sync strobe |
| bus_oe_o | output | 1 | Drive enable for the data bus pads |
| bus_out_o | output | 4 | Nibble driven onto the data bus |
| bus_in_i | input | 4 | Nibble received from the data bus |
| busy_o | output | 1 | A transaction is running |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Last transaction ended by poll timeout |
| data_o | output | 32 | Read result, held until the next start |

## Verification
The assertions check several rules on every cycle. Outputs never move while the port clock is high. The clock is parked low with sync high and the bus released whenever the master is idle. Done lasts one cycle, an error flag only appears with done, the ready code always leads to the sync-raise step, and a start during a transaction leaves the captured limit untouched. Other properties need the bench's target model: the exact nibble order on the bus, the single turnaround cycle, the number of polls before timeout (including the limit-of-zero and exact-limit boundaries), the port clock period, and the assembled data word. The model counts port clock edges and answers after a chosen number of waits.

// File: rtl/dbgrd_pkg.sv
package dbgrd_pkg;

    // nibble codes on the port bus, bit 3 leftmost
    localparam logic [3:0] NIB_START = 4'b0000;
    localparam logic [3:0] NIB_READ  = 4'b1010;
    localparam logic [3:0] NIB_READY = 4'b0001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_TURN,
        ST_POLL,
        ST_SYNCUP,
        ST_DATA,
        ST_FINISH
    } seq_state_e;

endpackage

// File: rtl/dbgrd_clkgen.sv
module dbgrd_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic pclk_o,
    output logic rise_stb_o,
    output logic fall_stb_o
);
    localparam int HALF = (HALF_DIV < 2) ? 2 : HALF_DIV;
    localparam int CW   = (HALF > 2) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          pclk;
    } cg_t;

    cg_t  cg_q, cg_d;
    logic wrap;

    always_comb begin
        cg_d = cg_q;
        wrap = (cg_q.cnt == CW'(HALF - 1));
        if (!en) begin
            cg_d.cnt  = '0;
            cg_d.pclk = 1'b0;
        end else if (wrap) begin
            cg_d.cnt  = '0;
            cg_d.pclk = ~cg_q.pclk;
        end else begin
            cg_d.cnt = cg_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cg_q <= '0;
        else        cg_q <= cg_d;
    end

    assign pclk_o     = cg_q.pclk;
    assign rise_stb_o = en & wrap & ~cg_q.pclk;
    assign fall_stb_o = en & wrap &  cg_q.pclk;

endmodule

// File: rtl/dbgrd_nibshift.sv
module dbgrd_nibshift #(
    parameter int NIBBLES = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [4*NIBBLES-1:0] load_val,
    input  logic                 shift,
    input  logic [3:0]           nib_in,
    output logic [4*NIBBLES-1:0] q_o
);
    localparam int W = 4 * NIBBLES;

    logic [W-1:0] sr_q, sr_d;

    always_comb begin
        sr_d = sr_q;
        if (load)       sr_d = load_val;
        else if (shift) sr_d = {nib_in, sr_q[W-1:4]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign q_o = sr_q;

endmodule

// File: rtl/dbgrd_seq.sv
module dbgrd_seq
    import dbgrd_pkg::*;
#(
    parameter int NIBBLES = 8,
    parameter int POLL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [POLL_W-1:0] limit_i,
    input  logic              rise_stb_i,
    input  logic              fall_stb_i,
    input  logic [3:0]        bus_in_i,
    input  logic [3:0]        addr_nib_i,
    output logic              busy_o,
    output logic              sync_n_o,
    output logic              bus_oe_o,
    output logic [3:0]        bus_out_o,
    output logic              done_o,
    output logic              error_o,
    output logic              load_o,
    output logic              addr_shift_o,
    output logic              cap_shift_o
);
    localparam int SW        = $clog2(NIBBLES + 2);
    localparam int LAST_HDR  = NIBBLES + 1;
    localparam int LAST_DATA = NIBBLES - 1;

    typedef struct packed {
        seq_state_e        state;
        logic [SW-1:0]     step;
        logic [POLL_W-1:0] pcnt;
        logic [POLL_W-1:0] lim;
        logic              timeout;
        logic              sync_n;
        logic              oe;
        logic              done;
        logic              err;
    } seq_t;

    seq_t          s_q, s_d;
    logic [POLL_W:0] pnext;

    always_comb begin
        s_d          = s_q;
        s_d.done     = 1'b0;
        load_o       = 1'b0;
        addr_shift_o = 1'b0;
        cap_shift_o  = 1'b0;
        pnext        = {1'b0, s_q.pcnt} + 1'b1;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.state   = ST_HDR;
                    s_d.step    = '0;
                    s_d.pcnt    = '0;
                    s_d.lim     = limit_i;
                    s_d.timeout = 1'b0;
                    s_d.sync_n  = 1'b0;
                    s_d.oe      = 1'b1;
                    s_d.err     = 1'b0;
                    load_o      = 1'b1;
                end
            end
            ST_HDR: begin
                if (fall_stb_i) begin
                    if (s_q.step >= SW'(2)) addr_shift_o = 1'b1;
                    if (s_q.step == SW'(LAST_HDR)) begin
                        s_d.state = ST_TURN;
                        s_d.oe    = 1'b0;
                    end else begin
                        s_d.step = s_q.step + 1'b1;
                    end
                end
            end
            ST_TURN: begin
                if (fall_stb_i) s_d.state = ST_POLL;
            end
            ST_POLL: begin
                if (rise_stb_i) begin
                    if (bus_in_i == NIB_READY) begin
                        s_d.state = ST_SYNCUP;
                    end else if (pnext >= {1'b0, s_q.lim}) begin
                        s_d.state   = ST_FINISH;
                        s_d.timeout = 1'b1;
                    end else begin
                        s_d.pcnt = pnext[POLL_W-1:0];
                    end
                end
            end
            ST_SYNCUP: begin
                if (fall_stb_i) begin
                    s_d.state  = ST_DATA;
                    s_d.sync_n = 1'b1;
                    s_d.step   = '0;
                end
            end
            ST_DATA: begin
                if (rise_stb_i) begin
                    cap_shift_o = 1'b1;
                    if (s_q.step == SW'(LAST_DATA)) s_d.state = ST_FINISH;
                    else                           s_d.step  = s_q.step + 1'b1;
                end
            end
            ST_FINISH: begin
                if (fall_stb_i) begin
                    s_d.state  = ST_IDLE;
                    s_d.sync_n = 1'b1;
                    s_d.done   = 1'b1;
                    s_d.err    = s_q.timeout;
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.state  <= ST_IDLE;
            s_q.sync_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_out_o = NIB_START;
        if (s_q.state == ST_HDR) begin
            if (s_q.step == SW'(1))       bus_out_o = NIB_READ;
            else if (s_q.step >= SW'(2))  bus_out_o = addr_nib_i;
        end
    end

    assign busy_o   = (s_q.state != ST_IDLE);
    assign sync_n_o = s_q.sync_n;
    assign bus_oe_o = s_q.oe;
    assign done_o   = s_q.done;
    assign error_o  = s_q.err;

    // R8: completion pulse lasts one system clock
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> !s_q.done);

    // R10: a start during a transaction does not reload the poll limit
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state != ST_IDLE && start_i) |=> $stable(s_q.lim));

    // R6: the ready code always moves polling to the sync-raise step
    p_ready_to_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.state == ST_POLL && rise_stb_i && bus_in_i == NIB_READY)
        |=> (s_q.state == ST_SYNCUP));

    // R9: the error flag only rises together with completion
    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.err) |-> s_q.done);

endmodule

// File: rtl/dbgrd_master.sv
module dbgrd_master #(
    parameter int HALF_DIV = 2,
    parameter int NIBBLES  = 8,
    parameter int POLL_W   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [4*NIBBLES-1:0] addr_i,
    input  logic [POLL_W-1:0]    poll_limit_i,
    output logic                 pclk_o,
    output logic                 sync_n_o,
    output logic                 bus_oe_o,
    output logic [3:0]           bus_out_o,
    input  logic [3:0]           bus_in_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic                 error_o,
    output logic [4*NIBBLES-1:0] data_o
);
    localparam int W = 4 * NIBBLES;

    logic         rise_stb, fall_stb;
    logic         load, addr_shift, cap_shift;
    logic [W-1:0] addr_q;

    dbgrd_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (busy_o),
        .pclk_o     (pclk_o),
        .rise_stb_o (rise_stb),
        .fall_stb_o (fall_stb)
    );

    dbgrd_seq #(.NIBBLES(NIBBLES), .POLL_W(POLL_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .limit_i      (poll_limit_i),
        .rise_stb_i   (rise_stb),
        .fall_stb_i   (fall_stb),
        .bus_in_i     (bus_in_i),
        .addr_nib_i   (addr_q[3:0]),
        .busy_o       (busy_o),
        .sync_n_o     (sync_n_o),
        .bus_oe_o     (bus_oe_o),
        .bus_out_o    (bus_out_o),
        .done_o       (done_o),
        .error_o      (error_o),
        .load_o       (load),
        .addr_shift_o (addr_shift),
        .cap_shift_o  (cap_shift)
    );

    // address register rotates so the next nibble is always at the bottom
    dbgrd_nibshift #(.NIBBLES(NIBBLES)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (addr_i),
        .shift    (addr_shift),
        .nib_in   (addr_q[3:0]),
        .q_o      (addr_q)
    );

    // capture register fills from the top, first nibble ends lowest
    dbgrd_nibshift #(.NIBBLES(NIBBLES)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val ('0),
        .shift    (cap_shift),
        .nib_in   (bus_in_i),
        .q_o      (data_o)
    );

    // R1: idle means parked clock, sync high, bus released
    p_idle_parked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!pclk_o && sync_n_o && !bus_oe_o));

    // R11: port outputs hold while the port clock stays high
    p_drive_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pclk_o && $past(pclk_o))
        |-> ($stable(bus_out_o) && $stable(bus_oe_o) && $stable(sync_n_o)));

    // R7: master never drives the bus once sync is high
    p_oe_off_sync_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sync_n_o |-> !bus_oe_o);

endmodule

// File: tb/tb_dbgrd_master.sv
`timescale 1ns/1ps
module tb_dbgrd_master;
    localparam int HALF = 3;
    localparam real TCLK = 4.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [15:0] poll_limit_i = '0;
    logic [3:0]  bus_in_i = 4'hF;
    logic        pclk_o, sync_n_o, bus_oe_o, busy_o, done_o, error_o;
    logic [3:0]  bus_out_o;
    logic [31:0] data_o;

    always #2 clk = ~clk;

    dbgrd_master #(.HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .poll_limit_i(poll_limit_i), .pclk_o(pclk_o), .sync_n_o(sync_n_o),
        .bus_oe_o(bus_oe_o), .bus_out_o(bus_out_o), .bus_in_i(bus_in_i),
        .busy_o(busy_o), .done_o(done_o), .error_o(error_o), .data_o(data_o)
    );

    int tests = 0;
    int fails = 0;

    // responder state
    int          rise_n = 0;
    int          r_wait = 0;
    logic [31:0] r_addr = '0;
    logic [31:0] r_data = '0;
    int          hdr_bad = 0, turn_bad = 0, sync_bad = 0;
    realtime     t_r1 = 0.0, t_r2 = 0.0;

    // {addr, data, wait count, poll limit}
    localparam logic [87:0] VEC [0:5] = '{
        {32'h1234_5678, 32'h89AB_CDEF, 8'd0, 16'd8},
        {32'hFFFF_C000, 32'h0123_4567, 8'd3, 16'd8},
        {32'hA5A5_0F0F, 32'hDEAD_BEEF, 8'd7, 16'd8},
        {32'h0000_0001, 32'h5555_AAAA, 8'd8, 16'd8},
        {32'h8000_0000, 32'hCAFE_F00D, 8'd0, 16'd0},
        {32'h7654_3210, 32'h1111_2222, 8'd2, 16'd0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] nib_for(input int n);
        if (n >= 12 && n < 12 + r_wait) return 4'h8;
        if (n == 12 + r_wait) return 4'h1;
        if (n >= 13 + r_wait && n <= 20 + r_wait) return r_data[4*(n-13-r_wait) +: 4];
        return 4'hF;
    endfunction

    // target model: checks what the master drives at each rising port clock
    initial begin
        forever begin
            @(posedge pclk_o);
            rise_n = rise_n + 1;
            if (rise_n == 1) t_r1 = $realtime;
            if (rise_n == 2) t_r2 = $realtime;
            if (rise_n == 1 && !(bus_out_o == 4'b0000 && bus_oe_o && !sync_n_o)) hdr_bad++;
            if (rise_n == 2 && !(bus_out_o == 4'b1010 && bus_oe_o && !sync_n_o)) hdr_bad++;
            if (rise_n >= 3 && rise_n <= 10 &&
                !(bus_out_o == r_addr[4*(rise_n-3) +: 4] && bus_oe_o && !sync_n_o)) hdr_bad++;
            if (rise_n >= 11 && bus_oe_o) turn_bad++;
            if (rise_n >= 11 && rise_n <= 12 + r_wait && sync_n_o) sync_bad++;
            if (rise_n >= 13 + r_wait && !sync_n_o) sync_bad++;
            bus_in_i = nib_for(rise_n + 1);
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic run_txn(input logic [31:0] a, input logic [31:0] d,
                           input int w, input logic [15:0] lim, input bit mid);
        int leff, exp_rises, g;
        bit exp_err;
        logic [31:0] held;
        leff      = (lim == 0) ? 1 : int'(lim);
        exp_err   = (w >= leff);
        exp_rises = exp_err ? 11 + leff : 20 + w;
        r_addr = a; r_data = d; r_wait = w;
        hdr_bad = 0; turn_bad = 0; sync_bad = 0; rise_n = 0;
        bus_in_i = 4'hF;
        addr_i = a; poll_limit_i = lim;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        if (mid) begin
            while (rise_n < 5) @(negedge clk);
            addr_i = ~a;
            poll_limit_i = 16'd1;
            start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
        end
        g = 0;
        while (!done_o && g < 4000) begin
            @(negedge clk);
            g++;
        end
        chk("R8 done seen", {31'd0, done_o}, 32'd1);
        chk("R9 error flag", {31'd0, error_o}, {31'd0, exp_err});
        chk("R7 data word", data_o, exp_err ? 32'd0 : d);
        chk("R3/R4 header nibbles (R10 when mid-start)", hdr_bad, 0);
        chk("R5 bus released after address", turn_bad, 0);
        chk("R7 sync low then high", sync_bad, 0);
        chk("R6 port clock rising edges", rise_n, exp_rises);
        chk("R9 sync high at end", {31'd0, sync_n_o}, 32'd1);
        held = data_o;
        @(negedge clk);
        chk("R8 done one cycle", {31'd0, done_o}, 32'd0);
        repeat (3 * HALF * 2) @(negedge clk);
        chk("R8 data held", data_o, held);
        chk("R8 no clock after done", rise_n, exp_rises);
        chk("R1 idle after done", {29'd0, pclk_o, bus_oe_o, busy_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset sync", {31'd0, sync_n_o}, 32'd1);
        chk("R1 reset outputs", {27'd0, pclk_o, bus_oe_o, busy_o, done_o, error_o}, 32'd0);
        chk("R1 reset data", data_o, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", {28'd0, pclk_o, bus_oe_o, busy_o, ~sync_n_o}, 32'd0);

        for (int i = 0; i < 6; i++) begin
            run_txn(VEC[i][87:56], VEC[i][55:24], int'(VEC[i][23:16]), VEC[i][15:0], 1'b0);
            if (i == 0) chk("R2 port clock period ps", int'((t_r2 - t_r1) * 1000.0),
                            int'(2.0 * HALF * TCLK * 1000.0));
        end

        // R10: start and new address while busy are ignored
        run_txn(32'h0BAD_F00D, 32'h600D_CAFE, 1, 16'd4, 1'b1);

        // R1: reset in the middle of a transaction parks the port
        r_addr = 32'h1357_9BDF; r_wait = 0; rise_n = 0;
        addr_i = r_addr; poll_limit_i = 16'd4;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        while (rise_n < 6) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-transaction reset", {28'd0, pclk_o, bus_oe_o, busy_o, ~sync_n_o}, 32'd0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule